// File: doc/BRIEF.md
# Debug bus access comparator pair

This block watches a processor bus and raises a match pulse whenever a valid access meets conditions programmed into two comparators, here called comparator A and comparator B. Each comparator holds a target address and a control word. Comparator A also holds a data value and a data mask, so it can qualify on the data carried by the access. Each comparator can match one exact address on its own. When both are enabled, they form a pair that matches an inclusive address window from A's address up to B's address.

Matches can be qualified by masked data with selectable polarity, by access direction, by the bus master that made the access and, for comparator B in exact mode, by access width. In window mode only comparator A's qualifiers apply. Comparator B's direction, size and master fields are then ignored. Configuration is written through a simple select/data write port. Every match output is registered and pulses for one cycle for each qualifying access.

Top module: `bus_watch_pair`

## Requirements
- R1: After reset every configuration register is zero, both comparators are disabled, and no match output is asserted for any access.
- R2: A write with `cfg_we` high stores `cfg_wdata` into the register chosen by `cfg_sel`. The select codes are: 0 = A address, 1 = A control, 2 = A data value, 3 = A data mask, 4 = B address, 5 = B control. A control bits: [0] enable, [1] direction check, [2] direction is read, [3] data invert, [4] master ID. B control bits: [0] enable, [1] direction check, [2] direction is read, [3] size check, [4] size is byte, [5] master ID.
- R3: With only A enabled, a valid access whose address equals A's address asserts `hit_a` in the cycle after the access. Any other address gives no match.
- R4: The data qualifier compares only the bit positions where A's mask holds 1. A mask of all zeros makes the data qualifier true, whatever the polarity.
- R5: With A's invert bit clear, the masked bus data must equal A's masked value. With the invert bit set, the masked data must differ from it.
- R6: With a comparator's direction-check bit clear, reads and writes both match. With it set, `bus_read` must equal the direction-is-read bit.
- R7: An access matches only when `bus_master` equals the comparator's master ID bit.
- R8: With only B enabled and its size-check bit clear, both byte and word accesses to B's address assert `hit_b`.
- R9: With B's size-check bit set, `bus_byte` must equal the size-is-byte bit (1 = byte only, 0 = word only). A word access starting at B's address minus one gives no match.
- R10: With both comparators enabled, `hit_range` pulses for accesses with A address <= address <= B address, both ends included. `hit_a` and `hit_b` stay low in this mode.
- R11: In window mode, data, direction and master qualifiers come only from comparator A. B's direction, size and master fields are ignored.
- R12: A match output pulses for exactly one cycle per qualifying access. A cycle with `bus_valid` low never produces a match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration register select |
| cfg_wdata | input | DATA_W | Configuration write data |
| bus_valid | input | 1 | Bus access strobe |
| bus_addr | input | ADDR_W | Access address |
| bus_data | input | DATA_W | Access data |
| bus_read | input | 1 | 1 = read, 0 = write |
| bus_byte | input | 1 | 1 = byte access, 0 = word access |
| bus_master | input | 1 | ID of the bus master that made the access |
| hit_a | output | 1 | Exact match pulse of comparator A |
| hit_b | output | 1 | Exact match pulse of comparator B |
| hit_range | output | 1 | Window match pulse of the pair |

## Verification
A corrupted configuration register shows up at the ports on the first access that tests the bad field. It appears one cycle after that access, as a pulse that is missing or extra. A wrong mode decode shows up as `hit_a` or `hit_b` firing where only `hit_range` should fire, which is why every window access checks all three outputs together. A stuck output flop shows up as a match in an idle cycle straight after a matching access. Each scenario therefore aims some accesses exactly at a boundary address and some one step outside it.

// File: rtl/bwp_pkg.sv
package bwp_pkg;

  // configuration register select codes
  localparam logic [2:0] SEL_A_ADDR = 3'd0;
  localparam logic [2:0] SEL_A_CTRL = 3'd1;
  localparam logic [2:0] SEL_A_VAL  = 3'd2;
  localparam logic [2:0] SEL_A_MASK = 3'd3;
  localparam logic [2:0] SEL_B_ADDR = 3'd4;
  localparam logic [2:0] SEL_B_CTRL = 3'd5;

  // comparator A control word, enable in bit 0
  typedef struct packed {
    logic master;
    logic invert;
    logic dir_rd;
    logic dir_chk;
    logic en;
  } a_ctrl_t;

  // comparator B control word, enable in bit 0
  typedef struct packed {
    logic master;
    logic size_byte;
    logic size_chk;
    logic dir_rd;
    logic dir_chk;
    logic en;
  } b_ctrl_t;

  localparam int A_CTRL_W = $bits(a_ctrl_t);
  localparam int B_CTRL_W = $bits(b_ctrl_t);

endpackage

// File: rtl/bwp_cfg.sv
module bwp_cfg
  import bwp_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_sel,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [ADDR_W-1:0] a_addr,
  output a_ctrl_t           a_ctrl,
  output logic [DATA_W-1:0] a_val,
  output logic [DATA_W-1:0] a_mask,
  output logic [ADDR_W-1:0] b_addr,
  output b_ctrl_t           b_ctrl
);

  logic [ADDR_W-1:0] a_addr_nxt, b_addr_nxt;
  a_ctrl_t           a_ctrl_nxt;
  b_ctrl_t           b_ctrl_nxt;
  logic [DATA_W-1:0] a_val_nxt, a_mask_nxt;

  always_comb begin
    a_addr_nxt = a_addr;
    a_ctrl_nxt = a_ctrl;
    a_val_nxt  = a_val;
    a_mask_nxt = a_mask;
    b_addr_nxt = b_addr;
    b_ctrl_nxt = b_ctrl;
    if (cfg_we) begin
      case (cfg_sel)
        SEL_A_ADDR: a_addr_nxt = ADDR_W'(cfg_wdata);
        SEL_A_CTRL: a_ctrl_nxt = a_ctrl_t'(cfg_wdata[A_CTRL_W-1:0]);
        SEL_A_VAL:  a_val_nxt  = cfg_wdata;
        SEL_A_MASK: a_mask_nxt = cfg_wdata;
        SEL_B_ADDR: b_addr_nxt = ADDR_W'(cfg_wdata);
        SEL_B_CTRL: b_ctrl_nxt = b_ctrl_t'(cfg_wdata[B_CTRL_W-1:0]);
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_addr <= '0;
      a_ctrl <= '0;
      a_val  <= '0;
      a_mask <= '0;
      b_addr <= '0;
      b_ctrl <= '0;
    end else begin
      a_addr <= a_addr_nxt;
      a_ctrl <= a_ctrl_nxt;
      a_val  <= a_val_nxt;
      a_mask <= a_mask_nxt;
      b_addr <= b_addr_nxt;
      b_ctrl <= b_ctrl_nxt;
    end
  end

  // R2
  a_ctrl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_sel == SEL_A_CTRL) |=> a_ctrl == $past(cfg_wdata[A_CTRL_W-1:0]));

  // R2
  b_addr_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_sel == SEL_B_ADDR) |=> b_addr == $past(ADDR_W'(cfg_wdata)));

endmodule

// File: rtl/bwp_dataq.sv
module bwp_dataq #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] cfg_val,
  input  logic [DATA_W-1:0] cfg_mask,
  input  logic              invert,
  input  logic [DATA_W-1:0] bus_data,
  output logic              data_ok
);

  logic [DATA_W-1:0] diff_bits;
  logic              any_diff;

  always_comb begin
    diff_bits = (bus_data ^ cfg_val) & cfg_mask;
    any_diff  = |diff_bits;
    if (cfg_mask == '0) data_ok = 1'b1;
    else                data_ok = invert ? any_diff : !any_diff;
  end

endmodule

// File: rtl/bwp_point.sv
module bwp_point #(
  parameter int ADDR_W = 16
) (
  input  logic              en,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic              dir_chk,
  input  logic              dir_rd,
  input  logic              cfg_master,
  input  logic              size_chk,
  input  logic              size_byte,
  input  logic              data_ok,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_read,
  input  logic              bus_byte,
  input  logic              bus_master,
  output logic              match
);

  logic addr_ok, dir_ok, size_ok, src_ok;

  always_comb begin
    addr_ok = (bus_addr == cfg_addr);
    dir_ok  = !dir_chk || (bus_read == dir_rd);
    size_ok = !size_chk || (bus_byte == size_byte);
    src_ok  = (bus_master == cfg_master);
    match   = en && addr_ok && dir_ok && size_ok && src_ok && data_ok;
  end

endmodule

// File: rtl/bwp_range.sv
module bwp_range #(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] lo_addr,
  input  logic [ADDR_W-1:0] hi_addr,
  input  logic              dir_chk,
  input  logic              dir_rd,
  input  logic              cfg_master,
  input  logic              data_ok,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_read,
  input  logic              bus_master,
  output logic              in_window
);

  logic above_lo, below_hi, dir_ok, src_ok;

  always_comb begin
    above_lo  = (bus_addr >= lo_addr);
    below_hi  = (bus_addr <= hi_addr);
    dir_ok    = !dir_chk || (bus_read == dir_rd);
    src_ok    = (bus_master == cfg_master);
    in_window = above_lo && below_hi && dir_ok && src_ok && data_ok;
  end

endmodule

// File: rtl/bus_watch_pair.sv
module bus_watch_pair
  import bwp_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 16,
  parameter int RST_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_sel,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              bus_valid,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_data,
  input  logic              bus_read,
  input  logic              bus_byte,
  input  logic              bus_master,
  output logic              hit_a,
  output logic              hit_b,
  output logic              hit_range
);

  localparam int HIT_N = 3;

  // reset: asserted asynchronously, released through a synchronizer
  logic [RST_STAGES-1:0] rst_pipe;
  logic                  rst_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[RST_STAGES-2:0], 1'b1};
  end
  assign rst_n_i = rst_pipe[RST_STAGES-1];

  logic [ADDR_W-1:0] a_addr, b_addr;
  a_ctrl_t           a_ctrl;
  b_ctrl_t           b_ctrl;
  logic [DATA_W-1:0] a_val, a_mask;

  bwp_cfg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .a_addr    (a_addr),
    .a_ctrl    (a_ctrl),
    .a_val     (a_val),
    .a_mask    (a_mask),
    .b_addr    (b_addr),
    .b_ctrl    (b_ctrl)
  );

  logic data_ok;

  bwp_dataq #(.DATA_W(DATA_W)) u_dataq (
    .cfg_val  (a_val),
    .cfg_mask (a_mask),
    .invert   (a_ctrl.invert),
    .bus_data (bus_data),
    .data_ok  (data_ok)
  );

  logic a_match, b_match, w_match;

  bwp_point #(.ADDR_W(ADDR_W)) u_point_a (
    .en         (a_ctrl.en),
    .cfg_addr   (a_addr),
    .dir_chk    (a_ctrl.dir_chk),
    .dir_rd     (a_ctrl.dir_rd),
    .cfg_master (a_ctrl.master),
    .size_chk   (1'b0),
    .size_byte  (1'b0),
    .data_ok    (data_ok),
    .bus_addr   (bus_addr),
    .bus_read   (bus_read),
    .bus_byte   (bus_byte),
    .bus_master (bus_master),
    .match      (a_match)
  );

  bwp_point #(.ADDR_W(ADDR_W)) u_point_b (
    .en         (b_ctrl.en),
    .cfg_addr   (b_addr),
    .dir_chk    (b_ctrl.dir_chk),
    .dir_rd     (b_ctrl.dir_rd),
    .cfg_master (b_ctrl.master),
    .size_chk   (b_ctrl.size_chk),
    .size_byte  (b_ctrl.size_byte),
    .data_ok    (1'b1),
    .bus_addr   (bus_addr),
    .bus_read   (bus_read),
    .bus_byte   (bus_byte),
    .bus_master (bus_master),
    .match      (b_match)
  );

  bwp_range #(.ADDR_W(ADDR_W)) u_range (
    .lo_addr    (a_addr),
    .hi_addr    (b_addr),
    .dir_chk    (a_ctrl.dir_chk),
    .dir_rd     (a_ctrl.dir_rd),
    .cfg_master (a_ctrl.master),
    .data_ok    (data_ok),
    .bus_addr   (bus_addr),
    .bus_read   (bus_read),
    .bus_master (bus_master),
    .in_window  (w_match)
  );

  // mode decode and next-state of the match pulses
  logic             window_mode;
  logic [HIT_N-1:0] hit_nxt, hit_q;

  always_comb begin
    window_mode = a_ctrl.en && b_ctrl.en;
    hit_nxt[0]  = bus_valid && !window_mode && a_match;
    hit_nxt[1]  = bus_valid && !window_mode && b_match;
    hit_nxt[2]  = bus_valid &&  window_mode && w_match;
  end

  for (genvar g = 0; g < HIT_N; g++) begin : g_hit
    always_ff @(posedge clk or negedge rst_n_i) begin
      if (!rst_n_i) hit_q[g] <= 1'b0;
      else          hit_q[g] <= hit_nxt[g];
    end
  end

  assign hit_a     = hit_q[0];
  assign hit_b     = hit_q[1];
  assign hit_range = hit_q[2];

  // R12
  a_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    hit_a |-> $past(bus_valid));

  // R12
  range_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    hit_range |-> $past(bus_valid));

  // R1
  a_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    hit_a |-> $past(a_ctrl.en));

  // R10
  window_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    hit_range |-> (!hit_a && !hit_b));

  // R10
  window_bounds_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    hit_range |-> (($past(bus_addr) >= $past(a_addr)) && ($past(bus_addr) <= $past(b_addr))));

  // R9
  b_size_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    (hit_b && $past(b_ctrl.size_chk)) |-> ($past(bus_byte) == $past(b_ctrl.size_byte)));

  // R3
  a_addr_exact_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    hit_a |-> ($past(bus_addr) == $past(a_addr)));

endmodule

// File: tb/bus_watch_pair_bench.sv
module bus_watch_pair_bench;

  localparam int ADDR_W = 16;
  localparam int DATA_W = 16;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              cfg_we;
  logic [2:0]        cfg_sel;
  logic [DATA_W-1:0] cfg_wdata;
  logic              bus_valid;
  logic [ADDR_W-1:0] bus_addr;
  logic [DATA_W-1:0] bus_data;
  logic              bus_read;
  logic              bus_byte;
  logic              bus_master;
  logic              hit_a, hit_b, hit_range;

  int checks = 0;
  int errors = 0;
  logic finished = 1'b0;

  always #2 clk = ~clk;

  bus_watch_pair #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bus_watch_pair (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .bus_valid(bus_valid), .bus_addr(bus_addr),
    .bus_data(bus_data), .bus_read(bus_read), .bus_byte(bus_byte),
    .bus_master(bus_master), .hit_a(hit_a), .hit_b(hit_b), .hit_range(hit_range)
  );

  task automatic check(input string tag, input logic [2:0] got, input logic [2:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: {a,b,range} actual %b expected %b", tag, got, exp);
    end
  endtask

  task automatic cfg(input logic [2:0] sel, input logic [DATA_W-1:0] val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // drive one access, return the outputs one cycle later
  task automatic access(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                        input logic rd, input logic byt, input logic mst,
                        input logic vld, output logic [2:0] hits);
    @(negedge clk);
    bus_valid = vld; bus_addr = a; bus_data = d;
    bus_read = rd; bus_byte = byt; bus_master = mst;
    @(posedge clk);
    #1 hits = {hit_a, hit_b, hit_range};
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic t_reset();
    logic [2:0] h;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0;
    bus_valid = 1'b0; bus_addr = '0; bus_data = '0;
    bus_read = 1'b0; bus_byte = 1'b0; bus_master = 1'b0;
    repeat (3) @(posedge clk);
    #1 check("R1 outputs in reset", {hit_a, hit_b, hit_range}, 3'b000);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    access(16'h0000, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b1, h);
    check("R1 zero config no match", h, 3'b000);
    access(16'h0000, 16'h0000, 1'b1, 1'b1, 1'b0, 1'b1, h);
    check("R1 zero config no match read byte", h, 3'b000);
  endtask

  task automatic t_exact_a();
    logic [2:0] h;
    cfg(3'd0, 16'h1234);
    cfg(3'd1, 16'h0001);
    access(16'h1234, 16'h5555, 1'b1, 1'b0, 1'b0, 1'b1, h);
    check("R3 exact address hit", h, 3'b100);
    access(16'h1235, 16'h5555, 1'b1, 1'b0, 1'b0, 1'b1, h);
    check("R3 neighbour address miss", h, 3'b000);
    access(16'h1233, 16'h5555, 1'b0, 1'b1, 1'b0, 1'b1, h);
    check("R3 lower address miss", h, 3'b000);
  endtask

  task automatic t_data();
    logic [2:0] h;
    cfg(3'd2, 16'h00A5);
    cfg(3'd3, 16'h00FF);
    access(16'h1234, 16'h12A5, 1'b0, 1'b0, 1'b0, 1'b1, h);
    check("R4 masked equal hit", h, 3'b100);
    access(16'h1234, 16'h12A4, 1'b0, 1'b0, 1'b0, 1'b1, h);
    check("R4 masked differ miss", h, 3'b000);
    cfg(3'd1, 16'h0009);
    access(16'h1234, 16'h12A4, 1'b0, 1'b0, 1'b0, 1'b1, h);
    check("R5 invert differ hit", h, 3'b100);
    access(16'h1234, 16'h33A5, 1'b0, 1'b0, 1'b0, 1'b1, h);
    check("R5 invert equal miss", h, 3'b000);
    cfg(3'd3, 16'h0000);
    access(16'h1234, 16'h00A5, 1'b0, 1'b0, 1'b0, 1'b1, h);
    check("R4 zero mask with invert hit", h, 3'b100);
    cfg(3'd1, 16'h0001);
  endtask

  task automatic t_direction();
    logic [2:0] h;
    cfg(3'd1, 16'h0007);
    access(16'h1234, 16'h0, 1'b1, 1'b0, 1'b0, 1'b1, h);
    check("R6 read-only read hit", h, 3'b100);
    access(16'h1234, 16'h0, 1'b0, 1'b0, 1'b0, 1'b1, h);
    check("R6 read-only write miss", h, 3'b000);
    cfg(3'd1, 16'h0003);
    access(16'h1234, 16'h0, 1'b0, 1'b0, 1'b0, 1'b1, h);
    check("R6 write-only write hit", h, 3'b100);
    access(16'h1234, 16'h0, 1'b1, 1'b0, 1'b0, 1'b1, h);
    check("R6 write-only read miss", h, 3'b000);
    cfg(3'd1, 16'h0005);
    access(16'h1234, 16'h0, 1'b0, 1'b0, 1'b0, 1'b1, h);
    check("R6 check off write hit", h, 3'b100);
  endtask

  task automatic t_master();
    logic [2:0] h;
    cfg(3'd1, 16'h0011);
    access(16'h1234, 16'h0, 1'b1, 1'b0, 1'b1, 1'b1, h);
    check("R7 master 1 hit", h, 3'b100);
    access(16'h1234, 16'h0, 1'b1, 1'b0, 1'b0, 1'b1, h);
    check("R7 master 0 miss", h, 3'b000);
    cfg(3'd1, 16'h0000);
  endtask

  task automatic t_size();
    logic [2:0] h;
    cfg(3'd4, 16'h2000);
    cfg(3'd5, 16'h0001);
    access(16'h2000, 16'h0, 1'b0, 1'b1, 1'b0, 1'b1, h);
    check("R8 size off byte hit", h, 3'b010);
    access(16'h2000, 16'h0, 1'b0, 1'b0, 1'b0, 1'b1, h);
    check("R8 size off word hit", h, 3'b010);
    cfg(3'd5, 16'h0009);
    access(16'h2000, 16'h0, 1'b0, 1'b0, 1'b0, 1'b1, h);
    check("R9 word-only word hit", h, 3'b010);
    access(16'h2000, 16'h0, 1'b0, 1'b1, 1'b0, 1'b1, h);
    check("R9 word-only byte miss", h, 3'b000);
    access(16'h1FFF, 16'h0, 1'b0, 1'b0, 1'b0, 1'b1, h);
    check("R9 word at n-1 miss", h, 3'b000);
    cfg(3'd5, 16'h0019);
    access(16'h2000, 16'h0, 1'b0, 1'b1, 1'b0, 1'b1, h);
    check("R9 byte-only byte hit", h, 3'b010);
    access(16'h2000, 16'h0, 1'b0, 1'b0, 1'b0, 1'b1, h);
    check("R9 byte-only word miss", h, 3'b000);
    cfg(3'd5, 16'h0000);
  endtask

  task automatic t_window();
    logic [2:0] h;
    cfg(3'd0, 16'h3000);
    cfg(3'd4, 16'h30FF);
    cfg(3'd1, 16'h0001);
    cfg(3'd5, 16'h0001);
    access(16'h3000, 16'h0, 1'b0, 1'b0, 1'b0, 1'b1, h);
    check("R10 lower bound hit, no exact", h, 3'b001);
    access(16'h30FF, 16'h0, 1'b1, 1'b1, 1'b0, 1'b1, h);
    check("R10 upper bound hit, no exact", h, 3'b001);
    access(16'h3080, 16'h0, 1'b0, 1'b0, 1'b0, 1'b1, h);
    check("R10 inside hit", h, 3'b001);
    access(16'h2FFF, 16'h0, 1'b0, 1'b0, 1'b0, 1'b1, h);
    check("R10 below miss", h, 3'b000);
    access(16'h3100, 16'h0, 1'b0, 1'b0, 1'b0, 1'b1, h);
    check("R10 above miss", h, 3'b000);
  endtask

  task automatic t_window_quals();
    logic [2:0] h;
    cfg(3'd5, 16'h003F);
    access(16'h3010, 16'h0, 1'b0, 1'b0, 1'b0, 1'b1, h);
    check("R11 B qualifiers ignored", h, 3'b001);
    cfg(3'd1, 16'h0003);
    access(16'h3010, 16'h0, 1'b0, 1'b0, 1'b0, 1'b1, h);
    check("R11 A write-only write hit", h, 3'b001);
    access(16'h3010, 16'h0, 1'b1, 1'b0, 1'b0, 1'b1, h);
    check("R11 A write-only read miss", h, 3'b000);
    cfg(3'd1, 16'h0001);
    cfg(3'd2, 16'h0005);
    cfg(3'd3, 16'h000F);
    access(16'h3010, 16'hFFF5, 1'b0, 1'b0, 1'b0, 1'b1, h);
    check("R11 A data equal hit", h, 3'b001);
    access(16'h3010, 16'h0006, 1'b0, 1'b0, 1'b0, 1'b1, h);
    check("R11 A data differ miss", h, 3'b000);
    cfg(3'd3, 16'h0000);
    cfg(3'd1, 16'h0011);
    access(16'h3010, 16'h0, 1'b0, 1'b0, 1'b0, 1'b1, h);
    check("R11 A master mismatch miss", h, 3'b000);
    access(16'h3010, 16'h0, 1'b0, 1'b0, 1'b1, 1'b1, h);
    check("R11 A master match hit", h, 3'b001);
    cfg(3'd1, 16'h0000);
    cfg(3'd5, 16'h0000);
  endtask

  task automatic t_pulse();
    logic [2:0] h;
    cfg(3'd0, 16'h4000);
    cfg(3'd1, 16'h0001);
    access(16'h4000, 16'h0, 1'b0, 1'b0, 1'b0, 1'b0, h);
    check("R12 no valid no hit", h, 3'b000);
    @(negedge clk);
    bus_valid = 1'b1; bus_addr = 16'h4000; bus_read = 1'b0;
    bus_byte = 1'b0; bus_master = 1'b0;
    @(posedge clk);
    #1 check("R12 first of two hits", {hit_a, hit_b, hit_range}, 3'b100);
    @(posedge clk);
    #1 check("R12 second of two hits", {hit_a, hit_b, hit_range}, 3'b100);
    @(negedge clk); bus_valid = 1'b0;
    @(posedge clk);
    #1 check("R12 pulse ends", {hit_a, hit_b, hit_range}, 3'b000);
    cfg(3'd1, 16'h0000);
  endtask

  initial begin
    t_reset();
    t_exact_a();
    t_data();
    t_direction();
    t_master();
    t_size();
    t_window();
    t_window_quals();
    t_pulse();
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule